// File: doc/BRIEF.md
# Stream Packet Framer with Byte Escaping

This block is a byte-wide AXI4-Stream pipeline stage. It wraps each incoming packet in a frame that a receiver can split by searching for one unique byte value. A start marker goes out ahead of the first payload byte. A closing marker follows the byte that carries TLAST. Any payload byte that collides with one of the three framing values is replaced by a two-byte escape pair. The closing marker therefore never appears inside a frame body, and a downstream DMA engine can treat it as a reliable frame-complete trigger.

The framer works in a single pass and keeps no frame buffer. Its output is one registered stage. The upstream ready signal is withheld in three cases: while a start marker is issued, while the second byte of an escape pair is sent, and while the closing marker is sent. Downstream backpressure freezes the output and the internal state.

Top module: `pkt_framer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the framer returns to its idle state. In the cycle after such an edge, `m_tvalid` and `s_tready` are both 0.
- R2: When a packet's first byte becomes valid at the input, the framer first emits the start marker 0x7B. It does not accept any input byte in the first cycle that byte is offered.
- R3: Payload bytes other than 0x7B, 0x7D and 0x7E are sent unchanged, and byte order is preserved.
- R4: A payload byte equal to 0x7B, 0x7D or 0x7E is sent as two bytes: first 0x7D, then the original byte XOR 0x20.
- R5: In the cycle after a reserved byte is accepted, `s_tready` is 0. This holds the input while the second byte of the escape pair is pending.
- R6: After the input byte carrying `s_tlast` has been sent (as an escape pair if it is reserved), the end marker 0x7E is emitted with `m_tlast` = 1.
- R7: `m_tlast` is 1 only on an output byte of value 0x7E.
- R8: The value 0x7E appears on the output only as the final byte of a frame, with `m_tlast` = 1.
- R9: Once a frame has been fully accepted downstream and no new input is valid, `m_tvalid` stays 0. No idle fill bytes are produced.
- R10: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` at 1 and holds `m_tdata` and `m_tlast` unchanged.
- R11: A one-byte packet whose only byte is reserved produces exactly four bytes, in this order: 0x7B, 0x7D, the byte XOR 0x20, 0x7E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 8 | Input payload byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Framer accepts the input byte this cycle |
| s_tlast | input | 1 | Input byte is the last byte of its packet |
| m_tdata | output | 8 | Framed output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream accepts the output byte |
| m_tlast | output | 1 | Output byte is the frame's end marker |

## Verification
Two functions can fall in the same cycle: the framer can be issuing the second byte of an escape pair or a closing marker while the next packet's first byte is already waiting, and the downstream side can be stalling that same output byte. The bench sends packets back to back, with the final byte often reserved, and applies pseudo-random input gaps and output stalls. This makes the pending suffix, the new packet's start marker and the backpressure collide. Every accepted output byte is compared against a frame rebuilt arithmetically from the payload. Every stall is checked for a frozen byte, and each packet's first offered cycle is checked for a withheld ready.

// File: rtl/pkt_framer_pkg.sv
`timescale 1ns/1ps
package pkt_framer_pkg;

    // Sequencer phases of the framer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // between packets, start marker not yet sent
        ST_BODY = 2'd1,   // passing payload bytes
        ST_ESC2 = 2'd2,   // second byte of an escape pair pending
        ST_EOP  = 2'd3    // closing marker pending
    } fr_state_e;

endpackage

// File: rtl/pf_classify.sv
`timescale 1ns/1ps
module pf_classify #(
    parameter int                          DATA_W   = 8,
    parameter int                          NUM_RES  = 3,
    parameter logic [NUM_RES*DATA_W-1:0]   RES_VALS = '0,
    parameter logic [DATA_W-1:0]           ESC_MASK = 8'h20
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              is_res,
    output logic [DATA_W-1:0] byte_esc
);

    logic [NUM_RES-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_RES; g++) begin : g_cmp
            assign hit[g] = (byte_in == RES_VALS[g*DATA_W +: DATA_W]);
        end
    endgenerate

    assign is_res   = |hit;
    assign byte_esc = byte_in ^ ESC_MASK;

    // R4: reserved values are distinct, so a byte matches at most one of them
    always_comb begin
        p_res_unique_r4: assert ($onehot0(hit));
    end

endmodule

// File: rtl/pf_seq.sv
`timescale 1ns/1ps
module pf_seq
    import pkt_framer_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] SOP_VAL = 8'h7B,
    parameter logic [DATA_W-1:0] EOP_VAL = 8'h7E,
    parameter logic [DATA_W-1:0] ESC_VAL = 8'h7D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic              in_is_res,
    input  logic [DATA_W-1:0] in_esc_byte,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready
);

    typedef struct packed {
        fr_state_e         st;
        logic [DATA_W-1:0] pend;
        logic              pend_last;
        logic [DATA_W-1:0] odata;
        logic              ovalid;
        logic              olast;
    } seq_t;

    seq_t r_d, r_q;
    logic adv;

    always_comb begin
        r_d      = r_q;
        adv      = !r_q.ovalid || m_tready;
        s_tready = (r_q.st == ST_BODY) && adv;
        if (adv) begin
            r_d.ovalid = 1'b0;
            r_d.olast  = 1'b0;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (s_tvalid) begin
                        r_d.odata  = SOP_VAL;
                        r_d.ovalid = 1'b1;
                        r_d.st     = ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (s_tvalid) begin
                        r_d.ovalid = 1'b1;
                        if (in_is_res) begin
                            r_d.odata     = ESC_VAL;
                            r_d.pend      = in_esc_byte;
                            r_d.pend_last = s_tlast;
                            r_d.st        = ST_ESC2;
                        end else begin
                            r_d.odata = s_tdata;
                            r_d.st    = s_tlast ? ST_EOP : ST_BODY;
                        end
                    end
                end
                ST_ESC2: begin
                    r_d.odata  = r_q.pend;
                    r_d.ovalid = 1'b1;
                    r_d.st     = r_q.pend_last ? ST_EOP : ST_BODY;
                end
                ST_EOP: begin
                    r_d.odata  = EOP_VAL;
                    r_d.ovalid = 1'b1;
                    r_d.olast  = 1'b1;
                    r_d.st     = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign m_tdata  = r_q.odata;
    assign m_tvalid = r_q.ovalid;
    assign m_tlast  = r_q.olast;

    // R1: reset leaves the framer silent and not accepting
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!m_tvalid && !s_tready));

    // R2: the byte following a completed frame is either absent or a start marker
    p_sop_leads_r2: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> (!m_tvalid || m_tdata == SOP_VAL));

    // R4: accepting a reserved byte issues the escape prefix next
    p_esc_prefix_r4: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && in_is_res) |=> (m_tvalid && m_tdata == ESC_VAL));

    // R5: input held while the escaped byte is pending
    p_esc_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && in_is_res) |=> !s_tready);

    // R7: last flag only on the end marker
    p_last_on_eop_r7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tlast) |-> (m_tdata == EOP_VAL));

    // R8: end marker value never appears inside a frame body
    p_eop_only_end_r8: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tdata == EOP_VAL) |-> m_tlast);

    // R10: a stalled output byte is held
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

// File: rtl/pkt_framer.sv
`timescale 1ns/1ps
module pkt_framer #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] SOP_VAL  = 8'h7B,
    parameter logic [DATA_W-1:0] EOP_VAL  = 8'h7E,
    parameter logic [DATA_W-1:0] ESC_VAL  = 8'h7D,
    parameter logic [DATA_W-1:0] ESC_MASK = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);

    localparam int                        NUM_RES  = 3;
    localparam logic [NUM_RES*DATA_W-1:0] RES_VALS = {EOP_VAL, ESC_VAL, SOP_VAL};

    logic              is_res;
    logic [DATA_W-1:0] esc_byte;

    pf_classify #(
        .DATA_W   (DATA_W),
        .NUM_RES  (NUM_RES),
        .RES_VALS (RES_VALS),
        .ESC_MASK (ESC_MASK)
    ) u_classify (
        .byte_in  (s_tdata),
        .is_res   (is_res),
        .byte_esc (esc_byte)
    );

    pf_seq #(
        .DATA_W  (DATA_W),
        .SOP_VAL (SOP_VAL),
        .EOP_VAL (EOP_VAL),
        .ESC_VAL (ESC_VAL)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .s_tdata     (s_tdata),
        .s_tvalid    (s_tvalid),
        .s_tlast     (s_tlast),
        .s_tready    (s_tready),
        .in_is_res   (is_res),
        .in_esc_byte (esc_byte),
        .m_tdata     (m_tdata),
        .m_tvalid    (m_tvalid),
        .m_tlast     (m_tlast),
        .m_tready    (m_tready)
    );

endmodule

// File: tb/pkt_framer_bench.sv
`timescale 1ns/1ps
module pkt_framer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] s_tdata = 8'h00;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic       s_tlast = 1'b0;
    logic [7:0] m_tdata;
    logic       m_tvalid;
    logic       m_tready = 1'b1;
    logic       m_tlast;

    always #5 clk = ~clk;

    pkt_framer u_pkt_framer (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       l;
        logic [3:0] tag;
    } exp_t;

    exp_t       exp_q[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] pkt_buf [0:63];
    bit         bp_en = 1'b0;
    bit         gap_en = 1'b0;
    int         tag_ovr = 0;
    bit         esc_chk = 1'b0;
    logic [15:0] lf_drv = 16'hACE1;
    logic [15:0] lf_mon = 16'h1D2F;
    logic [15:0] lf_pay = 16'h5A5A;
    bit         hold_prev = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic       hold_last = 1'b0;

    function automatic logic [15:0] lf_step(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    function automatic bit is_rsv(input logic [7:0] b);
        return (b == 8'h7B) || (b == 8'h7D) || (b == 8'h7E);
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int tg(input int t);
        return (tag_ovr != 0) ? tag_ovr : t;
    endfunction

    // Monitor: drives downstream ready, checks every transfer and every stall
    always @(negedge clk) begin
        lf_mon = lf_step(lf_mon);
        m_tready = bp_en ? (lf_mon[0] | lf_mon[3]) : 1'b1;
        #2;
        if (!rst) begin
            if (hold_prev) begin
                chk(m_tvalid && m_tdata == hold_data && m_tlast == hold_last, "R10",
                    {m_tvalid, m_tlast, m_tdata}, {1'b1, hold_last, hold_data});
            end
            hold_prev = m_tvalid && !m_tready;
            hold_data = m_tdata;
            hold_last = m_tlast;
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", m_tdata, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_tdata == e.d && m_tlast == e.l, tag_name(int'(e.tag)),
                        {m_tlast, m_tdata}, {e.l, e.d});
                end
                if (m_tlast) chk(m_tdata == 8'h7E, "R7", m_tdata, 8'h7E);
                if (m_tdata == 8'h7E) chk(m_tlast, "R8", m_tlast, 1);
            end
        end
    end

    task automatic send_packet(input int len);
        int  idx = 0;
        bit  first = 1'b1;
        bit  taken = 1'b0;
        exp_q.push_back('{d: 8'h7B, l: 1'b0, tag: 4'(tg(2))});
        for (int i = 0; i < len; i++) begin
            if (is_rsv(pkt_buf[i])) begin
                exp_q.push_back('{d: 8'h7D, l: 1'b0, tag: 4'(tg(4))});
                exp_q.push_back('{d: pkt_buf[i] ^ 8'h20, l: 1'b0, tag: 4'(tg(4))});
            end else begin
                exp_q.push_back('{d: pkt_buf[i], l: 1'b0, tag: 4'(tg(3))});
            end
        end
        exp_q.push_back('{d: 8'h7E, l: 1'b1, tag: 4'(tg(6))});
        while (idx < len) begin
            @(negedge clk);
            if (taken) begin
                s_tvalid = 1'b0;
                taken = 1'b0;
            end
            lf_drv = lf_step(lf_drv);
            if (!s_tvalid) s_tvalid = gap_en ? (lf_drv[1] | lf_drv[4]) : 1'b1;
            s_tdata = pkt_buf[idx];
            s_tlast = (idx == len - 1);
            #1;
            if (esc_chk) begin
                chk(!s_tready, "R5", s_tready, 0);
                esc_chk = 1'b0;
            end
            if (s_tvalid && first) begin
                chk(!s_tready, "R2", s_tready, 0);
                first = 1'b0;
            end
            if (s_tvalid && s_tready) begin
                esc_chk = is_rsv(pkt_buf[idx]);
                idx++;
                taken = 1'b1;
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast = 1'b0;
        #1;
        if (esc_chk) begin
            chk(!s_tready, "R5", s_tready, 0);
            esc_chk = 1'b0;
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        chk(!m_tvalid, "R9", m_tvalid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, even with input offered
        s_tvalid = 1'b1;
        repeat (3) @(negedge clk);
        #3;
        chk(!m_tvalid, "R1", m_tvalid, 0);
        chk(!s_tready, "R1", s_tready, 0);
        s_tvalid = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // Plain payloads, no stalls or gaps (R3, R6)
        for (int i = 0; i < 12; i++) pkt_buf[i] = 8'(i * 23 + 1);
        send_packet(12);
        wait_drain();

        // Every byte value as a one-byte packet, with stalls and gaps (R3, R4)
        bp_en = 1'b1;
        gap_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            pkt_buf[0] = 8'(v);
            send_packet(1);
            wait_drain();
        end

        // Back-to-back packets of growing length, rich in reserved bytes
        for (int len = 1; len <= 30; len++) begin
            for (int i = 0; i < len; i++) begin
                lf_pay = lf_step(lf_pay);
                case (lf_pay[1:0])
                    2'd0: pkt_buf[i] = 8'h7B;
                    2'd1: pkt_buf[i] = 8'h7D;
                    2'd2: pkt_buf[i] = 8'h7E;
                    default: pkt_buf[i] = lf_pay[15:8];
                endcase
            end
            send_packet(len);
        end
        wait_drain();

        // R11: single reserved byte packet, exact four-byte frame
        tag_ovr = 11;
        pkt_buf[0] = 8'h7E;
        send_packet(1);
        wait_drain();
        pkt_buf[0] = 8'h7B;
        send_packet(1);
        wait_drain();
        tag_ovr = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule